// File: doc/BRIEF.md
# Nametable Mirroring Controller

This block sits on the cartridge side of a retro console and decides how the console's internal 2 KB of video RAM is folded into the four nametable slots the video processor addresses. The CPU selects the folding pattern by writing a small mode value anywhere in the upper half of its address space. The video side then gets the bank-select bit and the two chip enables (internal video RAM and cartridge pattern memory) straight from its own address lines, with no clock in that path.

The CPU bus is seen through its clock phase, its read/write line and the cartridge select strobe. That strobe is low only while the phase is high and address bit 15 is set, so it is the only sign of an upper-half access. Write data is valid only at the falling edge of the phase. The block therefore records whether the high phase was a qualifying write and loads the data bits at the first system clock edge that sees the phase low. The phase input is taken to be synchronous to the block clock.

Top module: `nt_mirror_ctl`

## Requirements
- R1: While `rst` is high, and after it is released with no write since, the mode is vertical (`vram_bank` equals `ppu_a10`).
- R2: A qualifying write loads `cpu_data_lo` into the mode at the first rising `clk` edge at which `cpu_phi` is sampled low after being high. The old mode remains in force while `cpu_phi` is still high.
- R3: A write made while `rom_sel_n` stays high for the whole high phase leaves the mode unchanged.
- R4: A read (`cpu_rw` high during the high phase) never changes the mode.
- R5: Mode 2'b10 (vertical) drives `vram_bank` from `ppu_a10`. Mode 2'b11 (horizontal) drives it from `ppu_a11`.
- R6: Mode 2'b00 holds `vram_bank` at 0 and mode 2'b01 holds it at 1, whatever the video address.
- R7: `vram_ce_n` is low exactly when `ppu_a13` is high, so the internal video RAM answers at $2000–$3FFF.
- R8: `pat_ce_n` is low exactly when `ppu_a13` is low, so pattern memory answers at $0000–$1FFF.
- R9: All three video-side outputs follow their address inputs in the same cycle, through combinational logic only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the CPU bus |
| rst | input | 1 | Synchronous active-high reset |
| cpu_phi | input | 1 | CPU clock phase; bus address stable while high |
| cpu_rw | input | 1 | High for CPU read, low for CPU write |
| rom_sel_n | input | 1 | Low when phase high and address bit 15 set |
| cpu_data_lo | input | 2 | CPU data bits [1:0], the mode value |
| ppu_a10 | input | 1 | Video address bit 10 |
| ppu_a11 | input | 1 | Video address bit 11 |
| ppu_a13 | input | 1 | Video address bit 13 |
| vram_bank | output | 1 | Bank select for the internal video RAM |
| vram_ce_n | output | 1 | Active-low enable for the internal video RAM |
| pat_ce_n | output | 1 | Active-low enable for pattern memory |

## Verification
The mode register is the only state in the block. A wrong mode shows on `vram_bank` as soon as the video address exercises the one address bit that separates the expected mode from the actual one. The bench therefore sweeps every `ppu_a10`/`ppu_a11`/`ppu_a13` combination after each write. During each write it holds `ppu_a10` and `ppu_a11` at opposite levels, so an update made one cycle early or late differs from the model in the very cycle it happens. Ignored writes and reads are checked in the same way, by showing that `vram_bank` keeps following the old mode.

// File: rtl/nt_mirror_ctl.sv
module nt_mirror_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_phi,
  input  logic       cpu_rw,
  input  logic       rom_sel_n,
  input  logic [1:0] cpu_data_lo,
  input  logic       ppu_a10,
  input  logic       ppu_a11,
  input  logic       ppu_a13,
  output logic       vram_bank,
  output logic       vram_ce_n,
  output logic       pat_ce_n
);
  localparam logic [1:0] MODE_ONE_LO = 2'b00;
  localparam logic [1:0] MODE_ONE_HI = 2'b01;
  localparam logic [1:0] MODE_VERT   = 2'b10;
  localparam logic [1:0] MODE_HORZ   = 2'b11;

  logic       phi_q;
  logic       wr_q;
  logic [1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi_q  <= 1'b0;
      wr_q   <= 1'b0;
      mode_q <= MODE_VERT;
    end else begin
      phi_q <= cpu_phi;
      if (cpu_phi)
        wr_q <= !rom_sel_n && !cpu_rw;
      if (phi_q && !cpu_phi && wr_q)
        mode_q <= cpu_data_lo;
    end
  end

  always_comb begin
    unique case (mode_q)
      MODE_ONE_LO: vram_bank = 1'b0;
      MODE_ONE_HI: vram_bank = 1'b1;
      MODE_VERT:   vram_bank = ppu_a10;
      MODE_HORZ:   vram_bank = ppu_a11;
      default:     vram_bank = 1'b0;
    endcase
  end

  assign vram_ce_n = !ppu_a13;
  assign pat_ce_n  = ppu_a13;
endmodule

// File: rtl/nt_mirror_ctl_chk.sv
module nt_mirror_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_phi,
  input logic       cpu_rw,
  input logic       rom_sel_n,
  input logic       ppu_a10,
  input logic       ppu_a11,
  input logic [1:0] mode_q,
  input logic       vram_bank,
  input logic       vram_ce_n,
  input logic       pat_ce_n
);
  a_r2_update_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> (!$past(cpu_phi) && $past(cpu_phi, 2)));

  a_r3_needs_select: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> !$past(rom_sel_n, 2));

  a_r4_read_ignored: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> !$past(cpu_rw, 2));

  a_r1_reset_vertical: assert property (@(posedge clk)
    $past(rst) |-> (mode_q == 2'b10));

  a_r5_vertical: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b10) |-> (vram_bank == ppu_a10));

  a_r5_horizontal: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11) |-> (vram_bank == ppu_a11));

  a_r6_single_low: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b00) |-> !vram_bank);

  a_r7_one_enable: assert property (@(posedge clk) disable iff (rst)
    $countones({vram_ce_n, pat_ce_n}) == 1);
endmodule

bind nt_mirror_ctl nt_mirror_ctl_chk u_chk (
  .clk(clk), .rst(rst), .cpu_phi(cpu_phi), .cpu_rw(cpu_rw),
  .rom_sel_n(rom_sel_n), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
  .mode_q(mode_q), .vram_bank(vram_bank), .vram_ce_n(vram_ce_n),
  .pat_ce_n(pat_ce_n)
);

// File: tb/tb_nt_mirror_ctl.sv
module tb_nt_mirror_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_phi = 1'b0;
  logic       cpu_rw = 1'b1;
  logic       a15 = 1'b0;
  logic [1:0] cpu_data_lo = 2'b00;
  logic       ppu_a10 = 1'b0;
  logic       ppu_a11 = 1'b0;
  logic       ppu_a13 = 1'b0;
  logic       rom_sel_n;
  logic       vram_bank, vram_ce_n, pat_ce_n;

  int checks = 0;
  int failures = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  logic [1:0] exp_mode = 2'b10;

  assign rom_sel_n = !(cpu_phi && a15);

  always #2 clk = !clk;

  nt_mirror_ctl dut (
    .clk(clk), .rst(rst), .cpu_phi(cpu_phi), .cpu_rw(cpu_rw),
    .rom_sel_n(rom_sel_n), .cpu_data_lo(cpu_data_lo),
    .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ppu_a13(ppu_a13),
    .vram_bank(vram_bank), .vram_ce_n(vram_ce_n), .pat_ce_n(pat_ce_n)
  );

  function automatic logic model_bank(input logic [1:0] m, input logic a10, input logic a11);
    if (m == 2'b00) return 1'b0;
    if (m == 2'b01) return 1'b1;
    if (m == 2'b10) return a10;
    return a11;
  endfunction

  // Reference comparison one time unit after each rising edge (R1, R2, R5, R6, R7, R8, R9)
  always @(posedge clk) begin
    #1;
    if (checking) begin
      logic eb;
      eb = model_bank(exp_mode, ppu_a10, ppu_a11);
      checks++;
      if (vram_bank !== eb) begin
        failures++;
        $display("FAIL R1/R2/R5/R6 vram_bank mode=%b a10=%b a11=%b actual=%b expected=%b",
                 exp_mode, ppu_a10, ppu_a11, vram_bank, eb);
      end
      checks++;
      if (vram_ce_n !== !ppu_a13) begin
        failures++;
        $display("FAIL R7 vram_ce_n actual=%b expected=%b", vram_ce_n, !ppu_a13);
      end
      checks++;
      if (pat_ce_n !== ppu_a13) begin
        failures++;
        $display("FAIL R8 pat_ce_n actual=%b expected=%b", pat_ce_n, ppu_a13);
      end
    end
  end

  // R9: mid-cycle change of video inputs must show without a clock edge
  task automatic comb_check();
    @(negedge clk);
    ppu_a10 = !ppu_a10; ppu_a11 = !ppu_a11; ppu_a13 = !ppu_a13;
    #0.5;
    checks++;
    if (vram_bank !== model_bank(exp_mode, ppu_a10, ppu_a11) || pat_ce_n !== ppu_a13) begin
      failures++;
      $display("FAIL R9 comb path actual=%b%b expected=%b%b", vram_bank, pat_ce_n,
               model_bank(exp_mode, ppu_a10, ppu_a11), ppu_a13);
    end
  endtask

  task automatic sweep();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {ppu_a13, ppu_a11, ppu_a10} = i[2:0];
    end
    comb_check();
  endtask

  // One CPU bus cycle; qualifies (R2) only when rw low and a15 high (R3, R4)
  task automatic cpu_cycle(input logic rw, input logic hi, input logic [1:0] d);
    @(negedge clk);
    ppu_a10 = 1'b1; ppu_a11 = 1'b0; ppu_a13 = 1'b1;
    cpu_rw = rw; a15 = hi; cpu_data_lo = d; cpu_phi = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cpu_phi = 1'b0;
    @(posedge clk);
    if (!rw && hi) exp_mode = d;
    @(negedge clk);
    cpu_rw = 1'b1; a15 = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    checking = 1'b1;
    sweep();                       // R1 vertical after reset
    cpu_cycle(1'b0, 1'b1, 2'b11);  // R2, R5 horizontal
    sweep();
    cpu_cycle(1'b0, 1'b0, 2'b10);  // R3 select high: ignored
    sweep();
    cpu_cycle(1'b1, 1'b1, 2'b10);  // R4 read: ignored
    sweep();
    cpu_cycle(1'b0, 1'b1, 2'b00);  // R6 single low
    sweep();
    cpu_cycle(1'b0, 1'b1, 2'b01);  // R6 single high
    sweep();
    cpu_cycle(1'b1, 1'b1, 2'b00);  // R4 read in single high
    sweep();
    cpu_cycle(1'b0, 1'b1, 2'b10);  // R5 vertical
    sweep();
    cpu_cycle(1'b0, 1'b0, 2'b01);  // R3 again
    sweep();
    @(negedge clk);
    rst = 1'b1; checking = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; exp_mode = 2'b10; checking = 1'b1;
    sweep();                       // R1 after second reset
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule